// File: doc/BRIEF.md
# Monotonic Security Level Controller

This block holds a protection level and decides, one request at a time, whether an access to a protected region may go ahead. Four regions are guarded: the program flash, the boot configuration bytes (boot status and boot vector), the security byte itself, and the read-only information bytes. A caller presents a region and an access kind. One cycle later the block answers with a grant pulse or a deny pulse.

A separate level-write port asks to change the protection level. The level can only move toward stronger protection. The only way back to the unprotected state is a full-chip erase strobe. The current level is always visible as an 8-bit code. Keeping the level in non-volatile storage and carrying out the flash operations are left to the surrounding logic.

Level codes, from weakest to strongest protection: FFh (open), FEh (write-locked) and FCh (read- and write-locked). Region encoding: 0 = flash, 1 = boot configuration, 2 = security byte, 3 = information bytes. Kind encoding: 0 = read, 1 = write, 2 = block erase, 3 = blank check.

Top module: `seclvl_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `level_code` is FCh and all four answer outputs are low.
- R2: A level write is granted only when its code is FFh, FEh or FCh and is strictly stronger than the current level, where the strength order is FFh < FEh < FCh. A granted write takes effect on the next cycle. A refused write pulses `lvl_deny` and leaves `level_code` unchanged.
- R3: A `chip_erase` strobe sets `level_code` to FFh on the next cycle. A level write in the same cycle is refused.
- R4: A read of region 0 or 1 is granted at FFh and FEh, and refused at FCh.
- R5: A write of region 0 or 1 is granted only at FFh.
- R6: A block erase (kind 2) is granted only for region 0 at FFh. Every other block erase is refused.
- R7: A blank check (kind 3) of region 0 is granted at every level. A blank check of any other region is refused.
- R8: A read of region 2 or 3 is always granted. Any other kind on region 2 or 3 is always refused.
- R9: Every cycle with `req_valid` high produces exactly one of `acc_grant` or `acc_deny`, high for one cycle, on the next cycle. A cycle without a request produces neither. Access requests never change `level_code`.
- R10: An access request is judged against the level held before any level write or erase in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_region | input | 2 | Region of the access (0 flash, 1 boot config, 2 security byte, 3 info) |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 block erase, 3 blank check) |
| lvl_wr_valid | input | 1 | Level-write request strobe |
| lvl_wr_code | input | 8 | Requested level code |
| chip_erase | input | 1 | Full-chip erase strobe; reopens the level |
| acc_grant | output | 1 | Access granted, one cycle after the request |
| acc_deny | output | 1 | Access refused, one cycle after the request |
| lvl_grant | output | 1 | Level write accepted |
| lvl_deny | output | 1 | Level write refused |
| level_code | output | 8 | Current protection level code |

## Verification
The bench sweeps all sixteen region and kind pairs at each of the three levels. This separates the read, write, erase and blank-check rules and shows that each one depends on the level only where the requirements say it does. Level writes are tried in several cases: with codes that are not level codes, with codes equal to the current level, with weaker codes, and with stronger codes. These cases separate "strictly stronger" from "different" or "at least as strong". Erase cycles that carry a level write and requests that share a cycle with a level change check the priority and the pre-update judging. A long random run then mixes all inputs against the behavioural model.

// File: rtl/seclvl_pkg.sv
// Shared types for the security level controller.
// Assumes the level is stored as a strength rank; codes exist only at the edge.
package seclvl_pkg;

    typedef enum logic [1:0] {
        RANK_OPEN  = 2'd0,
        RANK_WLOCK = 2'd1,
        RANK_RWLOCK = 2'd2
    } rank_t;

    typedef enum logic [1:0] {
        RG_FLASH = 2'd0,
        RG_BOOTCFG = 2'd1,
        RG_SECBYTE = 2'd2,
        RG_INFO = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        AK_READ = 2'd0,
        AK_WRITE = 2'd1,
        AK_BERASE = 2'd2,
        AK_BLANK = 2'd3
    } kind_t;

    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_OPEN   = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_WLOCK  = 8'hFE;
    localparam logic [CODE_W-1:0] CODE_RWLOCK = 8'hFC;

    // Map a rank to its external code.
    function automatic logic [CODE_W-1:0] rank_to_code(rank_t r);
        case (r)
            RANK_OPEN:  return CODE_OPEN;
            RANK_WLOCK: return CODE_WLOCK;
            default:    return CODE_RWLOCK;
        endcase
    endfunction

endpackage

// File: rtl/seclvl_store.sv
// Level register with one-way update.
// Accepts a level write only if it is a legal code and strictly stronger.
// An erase strobe forces the open rank and takes priority over a write.
// Assumes at most one level write per cycle.
module seclvl_store
    import seclvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              erase,
    output rank_t             rank,
    output logic              wr_ok
);
    rank_t req_rank;
    logic  req_legal;
    logic  past_ok;

    // Decode the requested code into a rank and flag illegal codes.
    always_comb begin
        req_legal = 1'b1;
        case (wr_code)
            CODE_OPEN:   req_rank = RANK_OPEN;
            CODE_WLOCK:  req_rank = RANK_WLOCK;
            CODE_RWLOCK: req_rank = RANK_RWLOCK;
            default: begin
                req_rank  = RANK_OPEN;
                req_legal = 1'b0;
            end
        endcase
    end

    // Decide whether this cycle's write is accepted.
    always_comb wr_ok = wr_valid && req_legal && !erase && (req_rank > rank);

    // Hold the rank; erase reopens, accepted writes raise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rank <= RANK_RWLOCK;
        else if (erase) rank <= RANK_OPEN;
        else if (wr_ok) rank <= req_rank;
    end

    // Mark cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(erase) |-> rank >= $past(rank));
    p_erase_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(erase) |-> rank == RANK_OPEN);
    p_rank_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rank != 2'd3);
endmodule

// File: rtl/seclvl_policy.sv
// Combinational access policy: region, kind and current rank -> permit.
// Assumes the rank passed in is the registered (pre-update) level.
module seclvl_policy
    import seclvl_pkg::*;
(
    input  rank_t   rank,
    input  region_t region,
    input  kind_t   kind,
    output logic    permit
);
    logic open_lvl;
    logic readable;

    // Derive the two level conditions the rules depend on.
    always_comb begin
        open_lvl = (rank == RANK_OPEN);
        readable = (rank != RANK_RWLOCK);
    end

    // Apply the per-region rule table.
    always_comb begin
        permit = 1'b0;
        case (region)
            RG_FLASH: begin
                case (kind)
                    AK_READ:   permit = readable;
                    AK_WRITE:  permit = open_lvl;
                    AK_BERASE: permit = open_lvl;
                    default:   permit = 1'b1;
                endcase
            end
            RG_BOOTCFG: begin
                case (kind)
                    AK_READ:  permit = readable;
                    AK_WRITE: permit = open_lvl;
                    default:  permit = 1'b0;
                endcase
            end
            default: permit = (kind == AK_READ);
        endcase
    end
endmodule

// File: rtl/seclvl_guard.sv
// Top of the security level controller.
// Judges access requests against the held level and registers one-cycle
// grant/deny answers; forwards level writes and erase to the store.
// Assumes inputs are synchronous to clk.
module seclvl_guard
    import seclvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_region,
    input  logic [1:0]        req_kind,
    input  logic              lvl_wr_valid,
    input  logic [CODE_W-1:0] lvl_wr_code,
    input  logic              chip_erase,
    output logic              acc_grant,
    output logic              acc_deny,
    output logic              lvl_grant,
    output logic              lvl_deny,
    output logic [CODE_W-1:0] level_code
);
    rank_t cur_rank;
    logic  wr_ok;
    logic  permit;
    logic  past_ok;

    seclvl_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (lvl_wr_valid),
        .wr_code  (lvl_wr_code),
        .erase    (chip_erase),
        .rank     (cur_rank),
        .wr_ok    (wr_ok)
    );

    seclvl_policy u_policy (
        .rank   (cur_rank),
        .region (region_t'(req_region)),
        .kind   (kind_t'(req_kind)),
        .permit (permit)
    );

    // Register the answers for both request ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_grant <= 1'b0;
            acc_deny  <= 1'b0;
            lvl_grant <= 1'b0;
            lvl_deny  <= 1'b0;
        end else begin
            acc_grant <= req_valid && permit;
            acc_deny  <= req_valid && !permit;
            lvl_grant <= lvl_wr_valid && wr_ok;
            lvl_deny  <= lvl_wr_valid && !wr_ok;
        end
    end

    // Present the level as its external code.
    always_comb level_code = rank_to_code(cur_rank);

    // Track that the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (acc_grant || acc_deny) == $past(req_valid));
    p_berase_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && acc_grant && $past(req_kind) == 2'd2 |-> $past(level_code) == CODE_OPEN);
    p_info_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(req_valid) && $past(req_region) >= 2'd2 && $past(req_kind) != 2'd0
        |-> acc_deny);
    p_rdlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(req_valid) && $past(req_region) <= 2'd1 && $past(req_kind) == 2'd0
        && $past(level_code) == CODE_RWLOCK |-> acc_deny);
    p_lvl_deny_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && lvl_deny && !$past(chip_erase) |-> $stable(level_code));
endmodule

// File: tb/sim_seclvl_guard.sv
module sim_seclvl_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [1:0] req_region;
    logic [1:0] req_kind;
    logic       lvl_wr_valid;
    logic [7:0] lvl_wr_code;
    logic       chip_erase;
    logic       acc_grant, acc_deny, lvl_grant, lvl_deny;
    logic [7:0] level_code;

    int n_tests = 0;
    int n_fail  = 0;
    int mlvl    = 2;   // model strength: 0 open, 1 write-locked, 2 fully locked
    bit done    = 0;

    always #2 clk = ~clk;

    seclvl_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
        .req_kind(req_kind), .lvl_wr_valid(lvl_wr_valid), .lvl_wr_code(lvl_wr_code),
        .chip_erase(chip_erase), .acc_grant(acc_grant), .acc_deny(acc_deny),
        .lvl_grant(lvl_grant), .lvl_deny(lvl_deny), .level_code(level_code)
    );

    function automatic int code_strength(logic [7:0] c);
        if (c == 8'hFF) return 0;
        if (c == 8'hFE) return 1;
        if (c == 8'hFC) return 2;
        return -1;
    endfunction

    function automatic logic [7:0] strength_code(int s);
        if (s == 0) return 8'hFF;
        if (s == 1) return 8'hFE;
        return 8'hFC;
    endfunction

    // Behavioural rule set written from the requirements.
    function automatic bit model_ok(int s, int rg, int kd);
        if (rg >= 2) return kd == 0;                  // R8
        if (kd == 0) return s < 2;                    // R4
        if (kd == 1) return s == 0;                   // R5
        if (kd == 2) return (rg == 0) && (s == 0);    // R6
        return rg == 0;                               // R7
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus plus comparison against the model.
    task automatic step(bit rv, int rg, int kd, bit lw, logic [7:0] code, bit ce, string ovr);
        string tag;
        bit eg, ed, lg, ld, ok, wok;
        int ws;
        @(negedge clk);
        req_valid = rv; req_region = rg[1:0]; req_kind = kd[1:0];
        lvl_wr_valid = lw; lvl_wr_code = code; chip_erase = ce;
        ok  = model_ok(mlvl, rg, kd);
        ws  = code_strength(code);
        wok = lw && !ce && (ws > mlvl);
        eg = rv && ok;  ed = rv && !ok;
        lg = wok;       ld = lw && !wok;
        if (ce) mlvl = 0;
        else if (wok) mlvl = ws;
        if (ovr != "") tag = ovr;
        else if (ce) tag = "R3";
        else if (lw) tag = "R2";
        else if (!rv) tag = "R9";
        else if (rg >= 2) tag = "R8";
        else if (kd == 0) tag = "R4";
        else if (kd == 1) tag = "R5";
        else if (kd == 2) tag = "R6";
        else tag = "R7";
        @(posedge clk);
        #1;
        chk(tag, "acc_grant", {7'd0, acc_grant}, {7'd0, eg});
        chk(tag, "acc_deny",  {7'd0, acc_deny},  {7'd0, ed});
        chk(tag, "lvl_grant", {7'd0, lvl_grant}, {7'd0, lg});
        chk(tag, "lvl_deny",  {7'd0, lvl_deny},  {7'd0, ld});
        chk(tag, "level_code", level_code, strength_code(mlvl));
    endtask

    task automatic sweep();
        for (int rg = 0; rg < 4; rg++)
            for (int kd = 0; kd < 4; kd++)
                step(1, rg, kd, 0, 8'h00, 0, "");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 0; req_region = 0; req_kind = 0;
        lvl_wr_valid = 0; lvl_wr_code = 0; chip_erase = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "level_code", level_code, 8'hFC);
        chk("R1", "answers", {4'd0, acc_grant, acc_deny, lvl_grant, lvl_deny}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 8'h00, 0, "R1");
        sweep();                                 // fully locked
        step(0, 0, 0, 1, 8'hFE, 0, "R2");         // weaker: refused
        step(0, 0, 0, 1, 8'h12, 0, "R2");         // illegal code
        step(0, 0, 0, 1, 8'hFC, 0, "R2");         // equal: refused
        step(1, 0, 1, 1, 8'hFC, 1, "R3");         // erase beats write
        sweep();                                 // open
        step(0, 0, 0, 1, 8'hFF, 0, "R2");         // equal at open
        step(0, 0, 0, 1, 8'hFD, 0, "R2");         // illegal
        step(1, 0, 1, 1, 8'hFE, 0, "R10");        // write judged at open
        sweep();                                 // write-locked
        step(0, 0, 0, 1, 8'hFF, 0, "R2");
        step(0, 0, 0, 1, 8'hFE, 0, "R2");
        step(1, 0, 0, 1, 8'hFC, 0, "R10");        // read judged at write-locked
        step(1, 0, 0, 0, 8'h00, 0, "R4");
        step(1, 0, 3, 0, 8'h00, 1, "R10");        // erase same cycle
        step(0, 0, 0, 1, 8'hFC, 0, "R2");         // open -> fully locked directly
        step(0, 0, 0, 0, 8'h00, 0, "R9");
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [7:0] c;
            r = int'($urandom % 8);
            c = (r < 2) ? 8'hFF : (r < 4) ? 8'hFE : (r < 6) ? 8'hFC : 8'($urandom);
            step(bit'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                 bit'($urandom % 3 == 0), c, bit'($urandom % 16 == 0), "");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule